// File: doc/BRIEF.md
# Commit-Guarded GPIO Pin Configuration Registers

This block holds the configuration for one 8-pin general-purpose I/O port. For each pin it stores an alternate-function select bit, a pull-up enable, a pull-down enable, a digital enable and a 4-bit pad-control code. It also holds a lock register and a commit mask. A simple register bus reads and writes these registers. The block turns the stored state into per-pin pad controls. A pin whose digital enable is clear never drives its pad, and the core sees a constant 0 from it.

Some pins are guarded because they carry debug-port or other critical signals. For a guarded pin, a write to its function, pull or enable bit is stored only if two things hold: the port has been unlocked with a 32-bit key, and that pin's commit bit is set. The commit mask can itself be changed only while the port is unlocked. Without parameter overrides, pins 0 to 3 leave reset as debug-port pins (function select on, digital enable on, pull-up on, pad code 1). Pin 7 leaves reset as a plain GPIO that is guarded. Pins 4 to 6 are ordinary. The active-low reset is the power-on reset, and it returns every pin to its reset state.

Top module: `gpio_guard_top`

## Requirements
- R1: After reset, with the default parameters: alternate-function select reads 0x0F, pull-up 0x0F, pull-down 0x00, digital enable 0x0F, pad control 0x00001111, commit mask 0x70 and lock 1.
- R2: Byte offsets on busAddr are: alternate function 0x420, pull-up 0x510, pull-down 0x514, digital enable 0x51C, lock 0x520, commit 0x524 and pad control 0x52C. In pad control, pin n owns bits 4n+3..4n. Every other register uses bit n for pin n. Unused upper bits read 0.
- R3: Writing 0x4C4F434B to the lock register unlocks the port, and lock then reads 0. Writing any other value locks the port, and lock then reads 1.
- R4: A write to the commit register changes the mask only while the port is unlocked. Commit bits of unguarded pins always read 1.
- R5: While the port is locked, writes leave the guarded pins' bits in the alternate-function, pull-up, pull-down and digital-enable registers unchanged.
- R6: While the port is unlocked, a guarded pin's bit in those registers still ignores writes if its commit bit is 0.
- R7: While the port is unlocked, a write to a guarded pin whose commit bit is 1 is stored.
- R8: Unguarded pins' bits, and all pad-control bits, take every write whatever the lock state.
- R9: When a stored write sets a pin's pull-up, the same pin's pull-down is cleared. When a stored write sets a pull-down, the pull-up is cleared.
- R10: padOe[n] equals digEnable[n] AND coreOutEn[n]. coreIn[n] equals digEnable[n] AND padIn[n]. Both follow a digital-enable change in the same cycle.
- R11: Reads of any other address return 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| busWr | input | 1 | Write strobe for the addressed register |
| busAddr | input | 12 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 8 | Raw receiver value from each pad |
| coreOutEn | input | 8 | Output enable requested by the core per pin |
| altFuncSel | output | 8 | Stored alternate-function select |
| pullUpEn | output | 8 | Stored pull-up enables |
| pullDownEn | output | 8 | Stored pull-down enables |
| digEnable | output | 8 | Stored digital enables |
| padCtl | output | 32 | Stored pad-control codes, 4 bits per pin |
| padOe | output | 8 | Gated output enable to the pads |
| coreIn | output | 8 | Gated input value to the core |

## Verification
Two functions can act on the same clock edge: a stored digital-enable write and the pad gating that depends on it. The bench holds padIn and coreOutEn all ones while digital-enable writes go in under each lock and commit state. It then compares coreIn and padOe with a behavioural model on every cycle. A gate that opens one cycle late, or opens for a write that should have been dropped, shows up as a mismatch on the cycle after the write edge. Pull-up and pull-down writes are judged the same way, because one stored write must change both registers in the same cycle.

// File: rtl/gpio_guard_pkg.sv
package gpio_guard_pkg;

  localparam int PINS = 8;

  // Which register the bus address selects
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ALT,
    SEL_PU,
    SEL_PD,
    SEL_DEN,
    SEL_LOCK,
    SEL_COMMIT,
    SEL_PCTL
  } regSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic            wrAlt;
    logic            wrPullUp;
    logic            wrPullDown;
    logic            wrDigEn;
    logic            wrPadCtl;
    logic [PINS-1:0] allowMask;
  } cfgStrobe_t;

endpackage

// File: rtl/gpio_guard_ctrl.sv
module gpio_guard_ctrl
  import gpio_guard_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter logic [PINS-1:0] GUARD_MASK = 8'h8F,
  parameter logic [31:0]     UNLOCK_KEY = 32'h4C4F434B,
  parameter logic [ADDR_W-1:0] OFF_ALT  = 12'h420,
  parameter logic [ADDR_W-1:0] OFF_PU   = 12'h510,
  parameter logic [ADDR_W-1:0] OFF_PD   = 12'h514,
  parameter logic [ADDR_W-1:0] OFF_DEN  = 12'h51C,
  parameter logic [ADDR_W-1:0] OFF_LOCK = 12'h520,
  parameter logic [ADDR_W-1:0] OFF_CMT  = 12'h524,
  parameter logic [ADDR_W-1:0] OFF_PCTL = 12'h52C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output cfgStrobe_t        strobe,
  output regSel_t           rdSel,
  output logic [DATA_W-1:0] ctlRdata
);

  localparam logic [PINS-1:0] OPEN_MASK = ~GUARD_MASK;

  logic            locked;
  logic [PINS-1:0] commitBits;
  logic            keyMatch;

  // Address decode
  always_comb begin
    unique case (busAddr)
      OFF_ALT:  rdSel = SEL_ALT;
      OFF_PU:   rdSel = SEL_PU;
      OFF_PD:   rdSel = SEL_PD;
      OFF_DEN:  rdSel = SEL_DEN;
      OFF_LOCK: rdSel = SEL_LOCK;
      OFF_CMT:  rdSel = SEL_COMMIT;
      OFF_PCTL: rdSel = SEL_PCTL;
      default:  rdSel = SEL_NONE;
    endcase
  end

  assign keyMatch = (busWdata[31:0] == UNLOCK_KEY);

  // Lock state: reset locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (busWr && rdSel == SEL_LOCK) begin
      locked <= !keyMatch;
    end
  end

  // Commit mask: open pins pinned to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commitBits <= OPEN_MASK;
    end else if (busWr && rdSel == SEL_COMMIT && !locked) begin
      commitBits <= busWdata[PINS-1:0] | OPEN_MASK;
    end
  end

  // Strobes
  always_comb begin
    strobe.wrAlt      = busWr && rdSel == SEL_ALT;
    strobe.wrPullUp   = busWr && rdSel == SEL_PU;
    strobe.wrPullDown = busWr && rdSel == SEL_PD;
    strobe.wrDigEn    = busWr && rdSel == SEL_DEN;
    strobe.wrPadCtl   = busWr && rdSel == SEL_PCTL;
    strobe.allowMask  = OPEN_MASK | (locked ? '0 : commitBits);
  end

  always_comb begin
    ctlRdata = '0;
    if (rdSel == SEL_LOCK)   ctlRdata[0]      = locked;
    if (rdSel == SEL_COMMIT) ctlRdata[PINS-1:0] = commitBits;
  end

  // R3: key unlocks on the next edge
  a_r3_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == OFF_LOCK && busWdata[31:0] == UNLOCK_KEY) |=> !locked);

  // R3: any other value relocks
  a_r3_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == OFF_LOCK && busWdata[31:0] != UNLOCK_KEY) |=> locked);

  // R4: commit mask frozen while locked
  a_r4_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(commitBits));

  // R4: open pins always committed
  a_r4_open_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    (commitBits & OPEN_MASK) == OPEN_MASK);

endmodule

// File: rtl/gpio_guard_dp.sv
module gpio_guard_dp
  import gpio_guard_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [PINS-1:0] DEBUG_MASK = 8'h0F,
  parameter logic [3:0]      DEBUG_CODE = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strobe,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   coreOutEn,
  output logic [PINS-1:0]   altFuncSel,
  output logic [PINS-1:0]   pullUpEn,
  output logic [PINS-1:0]   pullDownEn,
  output logic [PINS-1:0]   digEnable,
  output logic [4*PINS-1:0] padCtl,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   coreIn,
  output logic [DATA_W-1:0] dpRdata
);

  localparam int CTL_W = 4 * PINS;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic wBit;
    assign wBit = busWdata[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        altFuncSel[g] <= DEBUG_MASK[g];
        digEnable[g]  <= DEBUG_MASK[g];
        pullUpEn[g]   <= DEBUG_MASK[g];
        pullDownEn[g] <= 1'b0;
      end else if (strobe.allowMask[g]) begin
        if (strobe.wrAlt)   altFuncSel[g] <= wBit;
        if (strobe.wrDigEn) digEnable[g]  <= wBit;
        if (strobe.wrPullUp) begin
          pullUpEn[g] <= wBit;
          if (wBit) pullDownEn[g] <= 1'b0;
        end
        if (strobe.wrPullDown) begin
          pullDownEn[g] <= wBit;
          if (wBit) pullUpEn[g] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        padCtl[4*g +: 4] <= DEBUG_MASK[g] ? DEBUG_CODE : 4'h0;
      end else if (strobe.wrPadCtl) begin
        padCtl[4*g +: 4] <= busWdata[4*g +: 4];
      end
    end

    assign padOe[g]  = digEnable[g] & coreOutEn[g];
    assign coreIn[g] = digEnable[g] & padIn[g];
  end

  always_comb begin
    dpRdata = '0;
    unique case (rdSel)
      SEL_ALT:  dpRdata[PINS-1:0]  = altFuncSel;
      SEL_PU:   dpRdata[PINS-1:0]  = pullUpEn;
      SEL_PD:   dpRdata[PINS-1:0]  = pullDownEn;
      SEL_DEN:  dpRdata[PINS-1:0]  = digEnable;
      SEL_PCTL: dpRdata[CTL_W-1:0] = padCtl;
      default:  dpRdata = '0;
    endcase
  end

  // R5/R6: blocked pins keep their enable
  a_r6_blocked_den_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((digEnable ^ $past(digEnable)) & ~$past(strobe.allowMask)) == '0));

  // R5: blocked pins keep their function select
  a_r5_blocked_alt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((altFuncSel ^ $past(altFuncSel)) & ~$past(strobe.allowMask)) == '0));

  // R9: pulls never both on
  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pullUpEn & pullDownEn) == '0);

  // R10: disabled pins neither drive nor pass input
  a_r10_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ((padOe | coreIn) & ~digEnable) == '0);

endmodule

// File: rtl/gpio_guard_top.sv
module gpio_guard_top
  import gpio_guard_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter logic [PINS-1:0] DEBUG_MASK = 8'h0F,
  parameter logic [PINS-1:0] LOCKED_GPIO_MASK = 8'h80,
  parameter logic [3:0]      DEBUG_CODE = 4'h1,
  parameter logic [31:0]     UNLOCK_KEY = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   coreOutEn,
  output logic [PINS-1:0]   altFuncSel,
  output logic [PINS-1:0]   pullUpEn,
  output logic [PINS-1:0]   pullDownEn,
  output logic [PINS-1:0]   digEnable,
  output logic [4*PINS-1:0] padCtl,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   coreIn
);

  localparam logic [PINS-1:0] GUARD_MASK = DEBUG_MASK | LOCKED_GPIO_MASK;

  cfgStrobe_t        strobe;
  regSel_t           rdSel;
  logic [DATA_W-1:0] ctlRdata;
  logic [DATA_W-1:0] dpRdata;

  gpio_guard_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GUARD_MASK(GUARD_MASK),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .ctlRdata(ctlRdata)
  );

  gpio_guard_dp #(
    .DATA_W    (DATA_W),
    .DEBUG_MASK(DEBUG_MASK),
    .DEBUG_CODE(DEBUG_CODE)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .busWdata  (busWdata),
    .padIn     (padIn),
    .coreOutEn (coreOutEn),
    .altFuncSel(altFuncSel),
    .pullUpEn  (pullUpEn),
    .pullDownEn(pullDownEn),
    .digEnable (digEnable),
    .padCtl    (padCtl),
    .padOe     (padOe),
    .coreIn    (coreIn),
    .dpRdata   (dpRdata)
  );

  assign busRdata = ctlRdata | dpRdata;

endmodule

// File: tb/test_gpio_guard_top.sv
module test_gpio_guard_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  PROT = 8'h8F;
  localparam logic [7:0]  DBG  = 8'h0F;
  localparam logic [31:0] KEY  = 32'h4C4F434B;
  localparam logic [11:0] A_AF = 12'h420, A_PU = 12'h510, A_PD = 12'h514,
                          A_DEN = 12'h51C, A_LK = 12'h520, A_CM = 12'h524,
                          A_PC = 12'h52C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = 12'h000;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  padIn = 8'h00;
  logic [7:0]  coreOutEn = 8'h00;
  logic [7:0]  altFuncSel, pullUpEn, pullDownEn, digEnable, padOe, coreIn;
  logic [31:0] padCtl;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  gpio_guard_top i_gpio_guard_top (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .coreOutEn(coreOutEn), .altFuncSel(altFuncSel), .pullUpEn(pullUpEn),
    .pullDownEn(pullDownEn), .digEnable(digEnable), .padCtl(padCtl),
    .padOe(padOe), .coreIn(coreIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [7:0]  mAf, mPu, mPd, mDen, mCommit;
  logic [31:0] mPc;
  bit          mLocked;

  task automatic modelReset();
    mAf = DBG; mPu = DBG; mPd = 8'h00; mDen = DBG;
    mPc = 32'h00001111; mCommit = ~PROT; mLocked = 1;
  endtask

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      A_AF:  return {24'h0, mAf};
      A_PU:  return {24'h0, mPu};
      A_PD:  return {24'h0, mPd};
      A_DEN: return {24'h0, mDen};
      A_LK:  return {31'h0, mLocked};
      A_CM:  return {24'h0, mCommit};
      A_PC:  return mPc;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      modelReset();
    end else if (busWr) begin
      for (int i = 0; i < 8; i++) begin
        bit ok;
        bit v;
        ok = !PROT[i] || (!mLocked && mCommit[i]);
        v  = busWdata[i];
        if (ok) begin
          if (busAddr == A_AF)  mAf[i] = v;
          if (busAddr == A_DEN) mDen[i] = v;
          if (busAddr == A_PU) begin mPu[i] = v; if (v) mPd[i] = 0; end
          if (busAddr == A_PD) begin mPd[i] = v; if (v) mPu[i] = 0; end
        end
      end
      if (busAddr == A_PC) mPc = busWdata;
      if (busAddr == A_CM && !mLocked) mCommit = busWdata[7:0] | ~PROT;
      if (busAddr == A_LK) mLocked = (busWdata != KEY);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 rdata",       busRdata, expRead(busAddr));
      check("R10 padOe",      {24'h0, padOe},  {24'h0, mDen & coreOutEn});
      check("R10 coreIn",     {24'h0, coreIn}, {24'h0, mDen & padIn});
      check("R7 altFuncSel",  {24'h0, altFuncSel}, {24'h0, mAf});
      check("R9 pulls",       {16'h0, pullUpEn, pullDownEn}, {16'h0, mPu, mPd});
      check("R7 digEnable",   {24'h0, digEnable}, {24'h0, mDen});
      check("R8 padCtl",      padCtl, mPc);
    end
  end

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 0;
  endtask

  task automatic rdCheck(logic [11:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    busAddr = a;
    @(negedge clk);
    check(tag, busRdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    padIn = 8'hFF; coreOutEn = 8'hFF;

    // R1 reset state
    rdCheck(A_AF,  32'h0F, "R1 alt reset");
    rdCheck(A_PU,  32'h0F, "R1 pull-up reset");
    rdCheck(A_PD,  32'h00, "R1 pull-down reset");
    rdCheck(A_DEN, 32'h0F, "R1 enable reset");
    rdCheck(A_PC,  32'h00001111, "R1 pad-control reset");
    rdCheck(A_CM,  32'h70, "R1 commit reset");
    rdCheck(A_LK,  32'h1, "R1 lock reset");
    check("R10 coreIn after reset", {24'h0, coreIn}, 32'h0F);

    // R5/R8 locked writes
    wrReg(A_DEN, 32'hFF);
    rdCheck(A_DEN, 32'h7F, "R5 R8 enable while locked");
    wrReg(A_AF, 32'h00);
    rdCheck(A_AF, 32'h0F, "R5 alt while locked");
    wrReg(A_CM, 32'hFF);
    rdCheck(A_CM, 32'h70, "R4 commit while locked");
    wrReg(A_LK, 32'h12345678);
    rdCheck(A_LK, 32'h1, "R3 wrong key stays locked");

    // R3 unlock, R6 commit clear
    wrReg(A_LK, KEY);
    rdCheck(A_LK, 32'h0, "R3 key unlocks");
    wrReg(A_DEN, 32'h00);
    rdCheck(A_DEN, 32'h0F, "R6 enable unlocked no commit");

    // R4 commit writable, R7 applied
    wrReg(A_CM, 32'h81);
    rdCheck(A_CM, 32'hF1, "R4 commit while unlocked");
    wrReg(A_DEN, 32'h00);
    rdCheck(A_DEN, 32'h0E, "R7 enable clear committed");
    wrReg(A_DEN, 32'h80);
    rdCheck(A_DEN, 32'h8E, "R7 enable set committed");
    check("R10 coreIn follows", {24'h0, coreIn}, 32'h8E);

    // R9 pull exclusivity
    wrReg(A_PD, 32'h81);
    rdCheck(A_PD, 32'h81, "R9 pull-down set");
    rdCheck(A_PU, 32'h0E, "R9 pull-up cleared");
    wrReg(A_PU, 32'h01);
    rdCheck(A_PU, 32'h0F, "R9 pull-up set");
    rdCheck(A_PD, 32'h80, "R9 pull-down cleared");

    // Relock: R3, R5, R4
    wrReg(A_LK, 32'h0);
    rdCheck(A_LK, 32'h1, "R3 relock");
    wrReg(A_DEN, 32'h00);
    rdCheck(A_DEN, 32'h8E, "R5 guarded enable after relock");
    wrReg(A_CM, 32'h00);
    rdCheck(A_CM, 32'hF1, "R4 commit frozen after relock");

    // R8 pad control, R11 unused address
    wrReg(A_PC, 32'h12345678);
    rdCheck(A_PC, 32'h12345678, "R8 pad control while locked");
    wrReg(12'h600, 32'hFFFFFFFF);
    rdCheck(12'h600, 32'h0, "R11 unused address");
    rdCheck(A_AF, 32'h0F, "R11 unused write no effect");

    // R10 gating patterns
    @(posedge clk); #1 padIn = 8'hA5; coreOutEn = 8'h3C;
    @(negedge clk);
    check("R10 coreIn pattern", {24'h0, coreIn}, {24'h0, 8'hA5 & 8'h8E});
    check("R10 padOe pattern",  {24'h0, padOe},  {24'h0, 8'h3C & 8'h8E});

    repeat (2) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule